// File: doc/BRIEF.md
# Flash Controller Register Bank with Write Locks

This block is the software-facing register bank of a serial-flash interface controller. Software reaches it through a simple word-wide register bus. It holds three configuration words: direct read, direct write, and the user-mode command format. It also holds a command control/status word, a command opcode word, an address word, four transmit data words, four receive data words and a global configuration word. The configuration words, the opcode, the address and the transmit data go straight out to a separate command engine. That engine performs the serial transfers and returns receive data and a completion pulse. The transfers themselves happen outside this block.

Software cannot rewrite a configuration word once it sets the top bit of that word. A second bit in the user-mode configuration freezes only its format bits. The control/status word carries several mechanisms:

- a ready flag that software clears by writing 1 to it;
- a start bit that stays set until the engine reports completion;
- an interrupt enable;
- a software chip-select bit, whose transitions assert or release one of the active-low chip-select outputs.

Top module: `flash_regbank`

## Requirements
- R1: Word map by byte offset: direct-read config 0x00, direct-write config 0x04, user-mode config 0x08, control/status 0x0C, opcode 0x10, address 0x14, transmit words 0x20/0x24/0x28/0x2C, receive words 0x30/0x34/0x38/0x3C, global config 0x78. Any other offset, or one with address bits 1:0 nonzero, reads 0, and a write to it changes nothing.
- R2: A bus write to any of the three configuration words is discarded whole when bit 31 of that word is already 1.
- R3: While bit 30 of the user-mode config is 1 (and bit 31 is 0), a write updates that word except bits 10, 1 and 0, which keep their old values.
- R4: Control/status bit 24 (ready) is cleared by writing 1 to it and unchanged by writing 0. An engine completion pulse sets it, and completion wins over a same-cycle clear.
- R5: Writing 1 to control/status bit 0 gives a one-cycle `eng_start` pulse in the following cycle. Bit 0 then reads 1 until a completion pulse clears it. Writing 0 to it has no effect. A start written in the same cycle as a completion leaves bit 0 at 1.
- R6: When a write changes control/status bit 16 from 0 to 1, the asserted chip select is released. This does not happen if bit 0 is 1 in either the old or the written value.
- R7: When a write changes bit 16 from 1 to 0, chip select number equal to the old value of bits 9:8 is driven low, and any other select is driven high. A number of NUM_CS or more leaves all selects high.
- R8: Receive words ignore bus writes. The engine loads them via `rd_we`/`rd_idx`/`rd_data`.
- R9: Reset values: direct-read 0x0300100B, direct-write 0x03000002, user-mode 0x00000400, control/status 0x00010000, opcode 0x0000000B, global 0x0000000B, all others 0. All chip selects are high.
- R10: `irq` is 1 exactly when control/status bits 25 (enable) and 24 (ready) are both 1.
- R11: The engine-side outputs show the stored register contents, including writes discarded by a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write when selected |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_done | input | 1 | Engine completion pulse |
| rd_we | input | 1 | Engine receive-word write enable |
| rd_idx | input | 2 | Receive word index |
| rd_data | input | 32 | Receive word value |
| eng_start | output | 1 | One-cycle command start pulse |
| drd_cfg_o | output | 32 | Direct-read configuration |
| dwr_cfg_o | output | 32 | Direct-write configuration |
| uma_cfg_o | output | 32 | User-mode configuration |
| ctl_o | output | 32 | Control/status word |
| cmd_o | output | 32 | Opcode word |
| adr_o | output | 32 | Address word |
| glb_o | output | 32 | Global configuration |
| txd_o | output | 128 | Transmit words, word 0 in bits 31:0 |
| cs_n | output | NUM_CS | Active-low chip selects |
| irq | output | 1 | Ready interrupt |

## Verification
The engine's completion pulse and a software write to the control/status word can land in the same clock cycle. Both then change the ready flag and the start bit. The bench provokes this by issuing a control/status write that clears ready, driving the completion input high in that same cycle while a command is pending. It then reads the word back and expects ready still set, the start bit cleared and the interrupt raised. The chip-select cases are judged the same way against a start that is pending, either held over from earlier or written in the same word: with a start pending, a release request leaves the select low.

// File: rtl/flash_regbank_pkg.sv
package flash_regbank_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_CFG   = 3;
    localparam int unsigned NUM_DWORD = 4;

    // word indices (byte offset / 4)
    localparam logic [5:0] W_CTL  = 6'h03;
    localparam logic [5:0] W_CMD  = 6'h04;
    localparam logic [5:0] W_ADR  = 6'h05;
    localparam logic [5:0] W_TXD0 = 6'h08;
    localparam logic [5:0] W_RXD0 = 6'h0C;
    localparam logic [5:0] W_GLB  = 6'h1E;

    localparam logic [NUM_CFG-1:0][WORD_W-1:0] CFG_RST =
        {32'h0000_0400, 32'h0300_0002, 32'h0300_100B};
    localparam logic [WORD_W-1:0] CTL_RST = 32'h0001_0000;
    localparam logic [WORD_W-1:0] CMD_RST = 32'h0000_000B;
    localparam logic [WORD_W-1:0] GLB_RST = 32'h0000_000B;

    localparam int unsigned  LOCK_BIT  = 31;
    localparam int unsigned  FRZ_BIT   = 30;
    localparam logic [WORD_W-1:0] FRZ_MASK = 32'h0000_0403;

    localparam int unsigned B_IE   = 25;
    localparam int unsigned B_RDY  = 24;
    localparam int unsigned B_SWCS = 16;
    localparam int unsigned B_DEV  = 8;
    localparam int unsigned B_EXEC = 0;
endpackage

// File: rtl/fr_lockreg.sv
module fr_lockreg
    import flash_regbank_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_VAL  = '0,
    parameter bit                PART_FRZ = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);
    logic [WORD_W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we && !val_q[LOCK_BIT]) begin
            val_d = wdata;
            if (PART_FRZ && val_q[FRZ_BIT])
                val_d = (wdata & ~FRZ_MASK) | (val_q & FRZ_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST_VAL;
        else        val_q <= val_d;
    end

    assign q = val_q;

    // R2: a locked word does not move on a bus write
    a_r2_locked_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (we && val_q[LOCK_BIT]) |=> $stable(val_q));

    generate
        if (PART_FRZ) begin : g_frz_chk
            // R3: frozen format bits survive a write
            a_r3_frozen_bits: assert property (@(posedge clk) disable iff (!rst_n)
                (we && val_q[FRZ_BIT]) |=> ((val_q & FRZ_MASK) == ($past(val_q) & FRZ_MASK)));
        end
    endgenerate
endmodule

// File: rtl/fr_ctrl.sv
module fr_ctrl
    import flash_regbank_pkg::*;
#(
    parameter int unsigned NUM_CS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              eng_done,
    output logic [WORD_W-1:0] ctl,
    output logic              start,
    output logic              irq,
    output logic [NUM_CS-1:0] cs_n
);
    localparam logic [2:0] CS_LIM = 3'(NUM_CS);

    typedef struct packed {
        logic [WORD_W-1:0] ctl;
        logic              act;
        logic [1:0]        idx;
        logic              start;
    } ctl_state_t;

    ctl_state_t s_d, s_q;
    logic [WORD_W-1:0] nv;
    logic [1:0]        dev;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        nv        = wdata;
        dev       = s_q.ctl[B_DEV +: 2];
        if (we) begin
            nv[B_RDY] = wdata[B_RDY] ? 1'b0 : s_q.ctl[B_RDY];
            if (s_q.ctl[B_SWCS] != wdata[B_SWCS]) begin
                if (wdata[B_SWCS]) begin
                    if (!(wdata[B_EXEC] || s_q.ctl[B_EXEC]))
                        s_d.act = 1'b0;
                end else if ({1'b0, dev} < CS_LIM) begin
                    s_d.act = 1'b1;
                    s_d.idx = dev;
                end else begin
                    s_d.act = 1'b0;
                end
            end
            nv[B_EXEC] = wdata[B_EXEC] | s_q.ctl[B_EXEC];
            s_d.ctl    = nv;
            s_d.start  = wdata[B_EXEC];
        end
        if (eng_done) begin
            s_d.ctl[B_RDY]  = 1'b1;
            s_d.ctl[B_EXEC] = we & wdata[B_EXEC];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ctl: CTL_RST, act: 1'b0, idx: 2'd0, start: 1'b0};
        else        s_q <= s_d;
    end

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
            assign cs_n[i] = !(s_q.act && (s_q.idx == 2'(i)));
        end
    endgenerate

    assign ctl   = s_q.ctl;
    assign start = s_q.start;
    assign irq   = s_q.ctl[B_IE] & s_q.ctl[B_RDY];

    // R5: pending command held until completion
    a_r5_exec_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctl[B_EXEC] && !eng_done) |=> s_q.ctl[B_EXEC]);
    // R4: completion always leaves ready set
    a_r4_done_sets_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> s_q.ctl[B_RDY]);
    // R4: writing 0 to ready keeps it
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdata[B_RDY] && s_q.ctl[B_RDY]) |=> s_q.ctl[B_RDY]);
    // R6: plain release drives every select high
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[B_SWCS] && !s_q.ctl[B_SWCS] && !wdata[B_EXEC] && !s_q.ctl[B_EXEC])
        |=> (&cs_n));
    // R7: never more than one select low
    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
endmodule

// File: rtl/flash_regbank.sv
module flash_regbank
    import flash_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NUM_CS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [WORD_W-1:0]           bus_wdata,
    output logic [WORD_W-1:0]           bus_rdata,
    input  logic                        eng_done,
    input  logic                        rd_we,
    input  logic [1:0]                  rd_idx,
    input  logic [WORD_W-1:0]           rd_data,
    output logic                        eng_start,
    output logic [WORD_W-1:0]           drd_cfg_o,
    output logic [WORD_W-1:0]           dwr_cfg_o,
    output logic [WORD_W-1:0]           uma_cfg_o,
    output logic [WORD_W-1:0]           ctl_o,
    output logic [WORD_W-1:0]           cmd_o,
    output logic [WORD_W-1:0]           adr_o,
    output logic [WORD_W-1:0]           glb_o,
    output logic [NUM_DWORD*WORD_W-1:0] txd_o,
    output logic [NUM_CS-1:0]           cs_n,
    output logic                        irq
);
    typedef struct packed {
        logic [WORD_W-1:0]                cmd;
        logic [WORD_W-1:0]                adr;
        logic [WORD_W-1:0]                glb;
        logic [NUM_DWORD-1:0][WORD_W-1:0] txd;
        logic [NUM_DWORD-1:0][WORD_W-1:0] rxd;
    } bank_state_t;

    bank_state_t s_d, s_q;
    logic [5:0]  widx;
    logic        aligned, wr_hit, rx_slot;
    logic [NUM_CFG-1:0][WORD_W-1:0] cfg_q;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_sel && bus_wr && aligned;

    generate
        for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
            fr_lockreg #(.RST_VAL(CFG_RST[g]), .PART_FRZ(g == 2)) u_cfg (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_hit && (widx == 6'(g))),
                .wdata (bus_wdata),
                .q     (cfg_q[g])
            );
        end
    endgenerate

    fr_ctrl #(.NUM_CS(NUM_CS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_hit && (widx == W_CTL)),
        .wdata    (bus_wdata),
        .eng_done (eng_done),
        .ctl      (ctl_o),
        .start    (eng_start),
        .irq      (irq),
        .cs_n     (cs_n)
    );

    always_comb begin
        s_d     = s_q;
        rx_slot = 1'b0;
        if (wr_hit) begin
            if (widx == W_CMD) s_d.cmd = bus_wdata;
            if (widx == W_ADR) s_d.adr = bus_wdata;
            if (widx == W_GLB) s_d.glb = bus_wdata;
            for (int i = 0; i < NUM_DWORD; i++) begin
                if (widx == 6'(W_TXD0 + i)) s_d.txd[i] = bus_wdata;
                if (widx == 6'(W_RXD0 + i)) rx_slot = 1'b1;
            end
        end
        if (rd_we) s_d.rxd[rd_idx] = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cmd: CMD_RST, adr: '0, glb: GLB_RST, txd: '0, rxd: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int g = 0; g < NUM_CFG; g++)
                if (widx == 6'(g)) bus_rdata = cfg_q[g];
            if (widx == W_CTL) bus_rdata = ctl_o;
            if (widx == W_CMD) bus_rdata = s_q.cmd;
            if (widx == W_ADR) bus_rdata = s_q.adr;
            if (widx == W_GLB) bus_rdata = s_q.glb;
            for (int i = 0; i < NUM_DWORD; i++) begin
                if (widx == 6'(W_TXD0 + i)) bus_rdata = s_q.txd[i];
                if (widx == 6'(W_RXD0 + i)) bus_rdata = s_q.rxd[i];
            end
        end
    end

    assign drd_cfg_o = cfg_q[0];
    assign dwr_cfg_o = cfg_q[1];
    assign uma_cfg_o = cfg_q[2];
    assign cmd_o     = s_q.cmd;
    assign adr_o     = s_q.adr;
    assign glb_o     = s_q.glb;
    assign txd_o     = s_q.txd;

    // R8: bus writes to receive words leave them untouched
    a_r8_rx_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_slot && !rd_we) |=> $stable(s_q.rxd));
    // R1: misaligned accesses read as zero
    a_r1_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |-> (bus_rdata == '0));
endmodule

// File: tb/tb_flash_regbank.sv
`timescale 1ns/1ps
module tb_flash_regbank;
    localparam int K_RD = 0, K_CS = 1, K_IRQ = 2, K_START = 3, K_DRDO = 4;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic eng_done = 0, rd_we = 0;
    logic [1:0]  rd_idx = '0;
    logic [31:0] rd_data = '0;
    logic eng_start, irq;
    logic [31:0] drd_cfg_o, dwr_cfg_o, uma_cfg_o, ctl_o, cmd_o, adr_o, glb_o;
    logic [127:0] txd_o;
    logic [1:0]  cs_n;

    int checks = 0, errors = 0;
    bit finished = 0;
    item_t sb[$];

    always #2 clk = ~clk;

    flash_regbank #(.ADDR_W(8), .NUM_CS(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
        .eng_start(eng_start), .drd_cfg_o(drd_cfg_o), .dwr_cfg_o(dwr_cfg_o),
        .uma_cfg_o(uma_cfg_o), .ctl_o(ctl_o), .cmd_o(cmd_o), .adr_o(adr_o),
        .glb_o(glb_o), .txd_o(txd_o), .cs_n(cs_n), .irq(irq)
    );

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_CS:    act = {30'b0, cs_n};
                K_IRQ:   act = {31'b0, irq};
                K_START: act = {31'b0, eng_start};
                default: act = drd_cfg_o;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        sb.push_back('{K_RD, e, tag});
        @(negedge clk); #1;
    endtask

    task automatic exp_pin(input int k, input logic [31:0] e, input string tag);
        sb.push_back('{k, e, tag});
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit with_done = 0);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; eng_done = with_done;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; eng_done = 0;
    endtask

    task automatic done_pulse();
        @(posedge clk); #1; eng_done = 1;
        @(posedge clk); #1; eng_done = 0;
    endtask

    task automatic eng_rx(input logic [1:0] i, input logic [31:0] d);
        @(posedge clk); #1; rd_we = 1; rd_idx = i; rd_data = d;
        @(posedge clk); #1; rd_we = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R9 reset values
        exp_rd(8'h00, 32'h0300100B, "R9 direct-read reset");
        exp_rd(8'h04, 32'h03000002, "R9 direct-write reset");
        exp_rd(8'h08, 32'h00000400, "R9 user-mode reset");
        exp_rd(8'h0C, 32'h00010000, "R9 control reset");
        exp_rd(8'h10, 32'h0000000B, "R9 opcode reset");
        exp_rd(8'h78, 32'h0000000B, "R9 global reset");
        exp_rd(8'h14, 32'h0, "R9 address reset");
        exp_pin(K_CS, 32'h3, "R9 selects high");
        exp_pin(K_IRQ, 32'h0, "R9 irq low");

        // R1 map and unmapped
        wr(8'h14, 32'h12345678);
        exp_rd(8'h14, 32'h12345678, "R1 address word");
        wr(8'h24, 32'hA5A5_0001);
        exp_rd(8'h24, 32'hA5A5_0001, "R1 transmit word 1");
        wr(8'h40, 32'hFFFF_FFFF);
        exp_rd(8'h40, 32'h0, "R1 unmapped read");
        exp_rd(8'h18, 32'h0, "R1 gap read");
        wr(8'h79, 32'h1234);
        exp_rd(8'h78, 32'h0000000B, "R1 misaligned write ignored");

        // R8 receive words
        wr(8'h30, 32'hDEAD_BEEF);
        exp_rd(8'h30, 32'h0, "R8 bus write ignored");
        eng_rx(2'd2, 32'hCAFE_0042);
        exp_rd(8'h38, 32'hCAFE_0042, "R8 engine load");
        wr(8'h38, 32'h0);
        exp_rd(8'h38, 32'hCAFE_0042, "R8 bus write keeps value");

        // R3 partial freeze of user-mode config
        wr(8'h08, 32'h4000_0000);
        exp_rd(8'h08, 32'h4000_0000, "R3 freeze set");
        wr(8'h08, 32'h40FF_0403);
        exp_rd(8'h08, 32'h40FF_0000, "R3 frozen bits kept");
        wr(8'h08, 32'h0000_0000);
        wr(8'h08, 32'h0000_0403);
        exp_rd(8'h08, 32'h0000_0403, "R3 unfrozen write");

        // R2 lock and R11 engine view
        wr(8'h00, 32'h8000_0001);
        wr(8'h00, 32'h0000_0012);
        exp_rd(8'h00, 32'h8000_0001, "R2 direct-read locked");
        exp_pin(K_DRDO, 32'h8000_0001, "R11 engine view of locked word");
        wr(8'h08, 32'h8000_0403);
        wr(8'h08, 32'h0);
        exp_rd(8'h08, 32'h8000_0403, "R2 user-mode locked");

        // R5 start
        wr(8'h0C, 32'h0001_0001);
        exp_pin(K_START, 32'h1, "R5 start pulse");
        exp_pin(K_START, 32'h0, "R5 start one cycle");
        exp_rd(8'h0C, 32'h0001_0001, "R5 start pending");
        wr(8'h0C, 32'h0001_0000);
        exp_rd(8'h0C, 32'h0001_0001, "R5 zero does not clear start");
        done_pulse();
        exp_rd(8'h0C, 32'h0101_0000, "R5 completion clears start, R4 sets ready");

        // R4 ready clear rules
        wr(8'h0C, 32'h0001_0000);
        exp_rd(8'h0C, 32'h0101_0000, "R4 zero keeps ready");
        wr(8'h0C, 32'h0101_0000);
        exp_rd(8'h0C, 32'h0001_0000, "R4 one clears ready");

        // R10 interrupt
        wr(8'h0C, 32'h0201_0000);
        exp_pin(K_IRQ, 32'h0, "R10 enable without ready");
        wr(8'h0C, 32'h0201_0001);
        done_pulse();
        exp_pin(K_IRQ, 32'h1, "R10 irq raised");
        wr(8'h0C, 32'h0301_0000);
        exp_pin(K_IRQ, 32'h0, "R10 irq dropped on clear");

        // R4 collision: clear and completion in one cycle
        wr(8'h0C, 32'h0201_0001);
        wr(8'h0C, 32'h0301_0000, 1'b1);
        exp_rd(8'h0C, 32'h0301_0000, "R4 completion wins over clear");
        exp_pin(K_IRQ, 32'h1, "R10 irq after collision");
        wr(8'h0C, 32'h0101_0000);
        exp_rd(8'h0C, 32'h0001_0000, "R4 cleared after collision");
        // R5 start and completion in one cycle
        wr(8'h0C, 32'h0001_0001);
        wr(8'h0C, 32'h0101_0001, 1'b1);
        exp_rd(8'h0C, 32'h0101_0001, "R5 new start survives completion");
        done_pulse();
        wr(8'h0C, 32'h0101_0000);
        exp_rd(8'h0C, 32'h0001_0000, "R5 idle again");

        // R7 and R6 chip selects
        wr(8'h0C, 32'h0000_0100);
        exp_pin(K_CS, 32'h2, "R7 select uses old number 0");
        wr(8'h0C, 32'h0001_0100);
        exp_pin(K_CS, 32'h3, "R6 release");
        wr(8'h0C, 32'h0000_0300);
        exp_pin(K_CS, 32'h1, "R7 select number 1");
        wr(8'h0C, 32'h0001_0300);
        wr(8'h0C, 32'h0000_0000);
        exp_pin(K_CS, 32'h3, "R7 number 3 out of range");
        wr(8'h0C, 32'h0001_0000);
        wr(8'h0C, 32'h0000_0000);
        exp_pin(K_CS, 32'h2, "R7 select number 0 again");
        wr(8'h0C, 32'h0001_0001);
        exp_pin(K_CS, 32'h2, "R6 no release with start written");
        done_pulse();
        wr(8'h0C, 32'h0000_0000);
        wr(8'h0C, 32'h0100_0001);
        exp_rd(8'h0C, 32'h0000_0001, "R5 start with select forced");
        wr(8'h0C, 32'h0001_0000);
        exp_pin(K_CS, 32'h2, "R6 no release with start pending");
        done_pulse();
        wr(8'h0C, 32'h0100_0000);
        wr(8'h0C, 32'h0001_0000);
        exp_pin(K_CS, 32'h3, "R6 release after completion");

        @(negedge clk); #1;
        finished = 1;
        summary();
        $finish;
    end
endmodule